// File: doc/BRIEF.md
# Conditional Relative Branch Evaluator

This block resolves a relative branch for a small 16-bit processor core. When a request is accepted it captures a 4-bit condition code, the Sign, Zero, Carry and Overflow flags, a displacement word with its direction bit, the current program counter and an external-mode select. It then reports whether the branch is taken and which program counter comes next. A taken branch moves to the program counter plus two, plus or minus the displacement. A branch that is not taken falls through to the program counter plus two. The arithmetic wraps at 16 bits.

The low three bits of the code pick a base test on the flags, and the top bit inverts it. Base 000 is "always", so 0000 branches every time and 1000 never branches. In external mode the flags are ignored. The block drives the captured code onto a 4-bit select bus for two cycles, samples a single external input line in the second cycle, and branches only if that line reads 1.

The controller has five states. ST_IDLE accepts a request and goes to ST_COND, or to ST_EXT_DRIVE when external mode is set. ST_COND always goes to ST_RESULT. ST_EXT_DRIVE always goes to ST_EXT_SAMPLE, and ST_EXT_SAMPLE always goes to ST_RESULT. ST_RESULT always returns to ST_IDLE. When no request is present, ST_IDLE stays where it is.

Top module: `branch_eval`

## Requirements
- R1: After reset, ready is 1, done is 0, taken is 0, next_pc is 0 and ext_sel is 0.
- R2: A taken branch with disp_neg = 0 yields next_pc = pc + 2 + disp.
- R3: A taken branch with disp_neg = 1 yields next_pc = pc + 2 - disp.
- R4: A branch that is not taken yields next_pc = pc + 2.
- R5: Codes 0001, 0010, 0011 and 0100 are taken when C=1, O=1, S=0 and Z=1 respectively. Codes 1001, 1010, 1011 and 1100 are taken on the opposite value of the same flag.
- R6: Code 0101 is taken when S xor O is 1, and 1101 when it is 0. Code 0110 is taken when Z or (S xor O) is 1, and 1110 when that term is 0.
- R7: Code 0111 is taken when C xor S is 1, and 1111 when it is 0.
- R8: Code 0000 is always taken, and code 1000 is never taken, whatever the flags.
- R9: In external mode, ext_sel equals the captured code during the two cycles after acceptance and is 0 at all other times. taken equals the ext_in value present in the second of those cycles. The value of ext_in in the first cycle has no effect.
- R10: All program counter arithmetic wraps modulo 2^16.
- R11: A request is accepted only when ready is 1. The done output is high for exactly one cycle per accepted request: two clock edges after acceptance in flag mode and three in external mode. A request held high while the block is busy is ignored.
- R12: Inputs other than ext_in are captured at acceptance. Changing them afterwards does not alter the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Evaluation request, accepted when ready is 1 |
| cond | input | 4 | Condition code; the top bit inverts the base test |
| ext_mode | input | 1 | 1 selects the external-input branch mode |
| flag_s | input | 1 | Sign flag |
| flag_z | input | 1 | Zero flag |
| flag_c | input | 1 | Carry flag |
| flag_o | input | 1 | Overflow flag |
| disp | input | 16 | Displacement magnitude |
| disp_neg | input | 1 | Direction bit: 0 adds the displacement, 1 subtracts it |
| pc | input | 16 | Current program counter |
| ext_in | input | 1 | External condition line |
| ready | output | 1 | Block is idle and can accept a request |
| done | output | 1 | One-cycle pulse marking a valid result |
| taken | output | 1 | Branch decision, valid while done is high |
| next_pc | output | 16 | Next program counter, valid while done is high |
| ext_sel | output | 4 | External condition select, 0 when not in use |

## Verification
A controller stuck in the wrong state shows up within a cycle or two. Either done comes one edge early or late compared with acceptance, or ready stays low, or ext_sel carries a code outside the external window. A wrong capture or decode shows up at the very next done pulse as a wrong taken bit or next_pc. To expose this, every one of the sixteen codes is run against every flag combination, and the inputs are scrambled right after acceptance. In external mode, ext_in is driven to the opposite value during the first cycle of the window, so sampling in the wrong cycle flips the reported decision.

// File: rtl/bx_pkg.sv
package bx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_COND,
        ST_EXT_DRIVE,
        ST_EXT_SAMPLE,
        ST_RESULT
    } bx_state_e;

    typedef struct packed {
        logic s;
        logic z;
        logic c;
        logic o;
    } bx_flags_t;

endpackage

// File: rtl/bx_cond_eval.sv
module bx_cond_eval
    import bx_pkg::*;
#(
    parameter int CODE_W = 4
) (
    input  logic [CODE_W-1:0] code,
    input  bx_flags_t         flags,
    output logic              hit
);
    localparam int BASE_W = CODE_W - 1;

    logic [BASE_W-1:0] base_sel;
    logic              invert;
    logic              base_hit;
    logic              lt_term;

    assign base_sel = code[BASE_W-1:0];
    assign invert   = code[CODE_W-1];
    assign lt_term  = flags.s ^ flags.o;

    always_comb begin
        unique case (base_sel)
            BASE_W'(0): base_hit = 1'b1;
            BASE_W'(1): base_hit = flags.c;
            BASE_W'(2): base_hit = flags.o;
            BASE_W'(3): base_hit = ~flags.s;
            BASE_W'(4): base_hit = flags.z;
            BASE_W'(5): base_hit = lt_term;
            BASE_W'(6): base_hit = flags.z | lt_term;
            BASE_W'(7): base_hit = flags.c ^ flags.s;
            default:    base_hit = 1'b0;
        endcase
    end

    assign hit = base_hit ^ invert;

endmodule

// File: rtl/bx_target_calc.sv
module bx_target_calc #(
    parameter int PC_W = 16,
    parameter int STEP = 2
) (
    input  logic [PC_W-1:0] pc,
    input  logic [PC_W-1:0] disp,
    input  logic            disp_neg,
    input  logic            take,
    output logic [PC_W-1:0] next_pc
);
    logic [PC_W-1:0] seq_pc;
    logic [PC_W-1:0] branch_pc;

    assign seq_pc = pc + PC_W'(STEP);

    always_comb begin
        if (disp_neg) begin
            branch_pc = seq_pc - disp;
        end else begin
            branch_pc = seq_pc + disp;
        end
    end

    assign next_pc = take ? branch_pc : seq_pc;

endmodule

// File: rtl/branch_eval.sv
module branch_eval
    import bx_pkg::*;
#(
    parameter int PC_W   = 16,
    parameter int CODE_W = 4,
    parameter int STEP   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic [CODE_W-1:0] cond,
    input  logic              ext_mode,
    input  logic              flag_s,
    input  logic              flag_z,
    input  logic              flag_c,
    input  logic              flag_o,
    input  logic [PC_W-1:0]   disp,
    input  logic              disp_neg,
    input  logic [PC_W-1:0]   pc,
    input  logic              ext_in,
    output logic              ready,
    output logic              done,
    output logic              taken,
    output logic [PC_W-1:0]   next_pc,
    output logic [CODE_W-1:0] ext_sel
);
    bx_state_e st, st_nxt;

    logic [CODE_W-1:0] cond_q;
    logic              ext_q;
    bx_flags_t         flags_q;
    logic [PC_W-1:0]   disp_q;
    logic              neg_q;
    logic [PC_W-1:0]   pc_q;

    logic              taken_q;
    logic [PC_W-1:0]   npc_q;

    logic              cond_hit;
    logic              take_sel;
    logic [PC_W-1:0]   calc_pc;
    logic              accept;

    assign accept = (st == ST_IDLE) && req;

    bx_cond_eval #(.CODE_W(CODE_W)) u_cond (
        .code  (cond_q),
        .flags (flags_q),
        .hit   (cond_hit)
    );

    assign take_sel = (st == ST_EXT_SAMPLE) ? ext_in : cond_hit;

    bx_target_calc #(.PC_W(PC_W), .STEP(STEP)) u_tgt (
        .pc       (pc_q),
        .disp     (disp_q),
        .disp_neg (neg_q),
        .take     (take_sel),
        .next_pc  (calc_pc)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st <= ST_IDLE;
        end else begin
            st <= st_nxt;
        end
    end

    // transitions
    always_comb begin
        st_nxt = st;
        unique case (st)
            ST_IDLE: begin
                if (req) begin
                    st_nxt = ext_mode ? ST_EXT_DRIVE : ST_COND;
                end
            end
            ST_COND:       st_nxt = ST_RESULT;
            ST_EXT_DRIVE:  st_nxt = ST_EXT_SAMPLE;
            ST_EXT_SAMPLE: st_nxt = ST_RESULT;
            ST_RESULT:     st_nxt = ST_IDLE;
            default:       st_nxt = ST_IDLE;
        endcase
    end

    // outputs decoded from state
    always_comb begin
        ready   = 1'b0;
        done    = 1'b0;
        ext_sel = '0;
        unique case (st)
            ST_IDLE:       ready = 1'b1;
            ST_COND:       ;
            ST_EXT_DRIVE:  ext_sel = cond_q;
            ST_EXT_SAMPLE: ext_sel = cond_q;
            ST_RESULT:     done = 1'b1;
            default:       ;
        endcase
    end

    // capture of the request operands
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cond_q  <= '0;
            ext_q   <= 1'b0;
            flags_q <= '0;
            disp_q  <= '0;
            neg_q   <= 1'b0;
            pc_q    <= '0;
        end else if (accept) begin
            cond_q  <= cond;
            ext_q   <= ext_mode;
            flags_q <= '{s: flag_s, z: flag_z, c: flag_c, o: flag_o};
            disp_q  <= disp;
            neg_q   <= disp_neg;
            pc_q    <= pc;
        end
    end

    // result registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            taken_q <= 1'b0;
            npc_q   <= '0;
        end else if (st == ST_COND || st == ST_EXT_SAMPLE) begin
            taken_q <= take_sel;
            npc_q   <= calc_pc;
        end
    end

    assign taken   = taken_q;
    assign next_pc = npc_q;

endmodule

// File: rtl/branch_eval_chk.sv
module branch_eval_chk
    import bx_pkg::*;
#(
    parameter int PC_W   = 16,
    parameter int CODE_W = 4,
    parameter int STEP   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              ready,
    input  logic              done,
    input  logic              taken,
    input  logic [PC_W-1:0]   next_pc,
    input  logic [CODE_W-1:0] ext_sel,
    input  logic              ext_in,
    input  bx_state_e         st,
    input  logic [PC_W-1:0]   pc_q,
    input  logic [CODE_W-1:0] cond_q,
    input  logic              ext_q
);
    localparam logic [CODE_W-1:0] NEVER_CODE = {1'b1, {(CODE_W-1){1'b0}}};

    // R9
    sel_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (ext_sel == '0));

    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R11
    busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && req) |=> !ready);

    // R4
    seq_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !taken) |-> (next_pc == PC_W'(pc_q + PC_W'(STEP))));

    // R8
    never_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !ext_q && cond_q == NEVER_CODE) |-> !taken);

    // R8
    always_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !ext_q && cond_q == '0) |-> taken);

    // R9
    ext_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_EXT_SAMPLE) |=> (done && taken == $past(ext_in)));

    // R9
    ext_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_EXT_DRIVE) |=> (ext_sel == $past(ext_sel) && ext_sel == cond_q));

endmodule

bind branch_eval branch_eval_chk #(
    .PC_W   (PC_W),
    .CODE_W (CODE_W),
    .STEP   (STEP)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     (req),
    .ready   (ready),
    .done    (done),
    .taken   (taken),
    .next_pc (next_pc),
    .ext_sel (ext_sel),
    .ext_in  (ext_in),
    .st      (st),
    .pc_q    (pc_q),
    .cond_q  (cond_q),
    .ext_q   (ext_q)
);

// File: tb/tb_branch_eval.sv
module tb_branch_eval;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic [3:0]  cond = '0;
    logic        ext_mode = 1'b0;
    logic        flag_s = 1'b0, flag_z = 1'b0, flag_c = 1'b0, flag_o = 1'b0;
    logic [15:0] disp = '0;
    logic        disp_neg = 1'b0;
    logic [15:0] pc = '0;
    logic        ext_in = 1'b0;
    logic        ready, done, taken;
    logic [15:0] next_pc;
    logic [3:0]  ext_sel;

    int checks = 0;
    int errors = 0;

    logic [16:0] exp_q[$];
    string       tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    branch_eval dut (
        .clk(clk), .rst_n(rst_n), .req(req), .cond(cond), .ext_mode(ext_mode),
        .flag_s(flag_s), .flag_z(flag_z), .flag_c(flag_c), .flag_o(flag_o),
        .disp(disp), .disp_neg(disp_neg), .pc(pc), .ext_in(ext_in),
        .ready(ready), .done(done), .taken(taken), .next_pc(next_pc),
        .ext_sel(ext_sel)
    );

    task automatic chk(input logic ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // flags packed as {s,z,c,o}
    function automatic logic model_take(input logic [3:0] c, input logic [3:0] f);
        logic s, z, cy, o;
        {s, z, cy, o} = f;
        case (c)
            4'b0000: return 1'b1;
            4'b1000: return 1'b0;
            4'b0001: return cy;
            4'b1001: return !cy;
            4'b0010: return o;
            4'b1010: return !o;
            4'b0011: return !s;
            4'b1011: return s;
            4'b0100: return z;
            4'b1100: return !z;
            4'b0101: return s != o;
            4'b1101: return s == o;
            4'b0110: return z || (s != o);
            4'b1110: return !z && (s == o);
            4'b0111: return cy != s;
            default: return cy == s;
        endcase
    endfunction

    function automatic string code_tag(input logic [3:0] c);
        case (c[2:0])
            3'd0:                   return "R8";
            3'd1, 3'd2, 3'd3, 3'd4: return "R5";
            3'd5, 3'd6:             return "R6";
            default:                return "R7";
        endcase
    endfunction

    // driver: push expected result, then stimulate
    task automatic issue(input logic [3:0] c, input logic [3:0] f, input logic [15:0] d,
                         input logic neg, input logic [15:0] p, input logic ext,
                         input logic ev, input logic hold, input string tag);
        logic        tk;
        logic [15:0] seq, npc;
        tk  = ext ? ev : model_take(c, f);
        seq = p + 16'd2;
        npc = !tk ? seq : (neg ? seq - d : seq + d);
        exp_q.push_back({tk, npc});
        tag_q.push_back(tag);
        @(negedge clk);
        chk(ready == 1'b1, "R11 ready before request", 32'(ready), 32'd1);
        req = 1'b1; cond = c; {flag_s, flag_z, flag_c, flag_o} = f;
        disp = d; disp_neg = neg; pc = p; ext_mode = ext;
        ext_in = ev;
        @(negedge clk);
        // R12: scramble captured inputs
        req = hold; cond = ~c; {flag_s, flag_z, flag_c, flag_o} = ~f;
        disp = ~d; disp_neg = ~neg; pc = ~p; ext_mode = ~ext;
        if (ext) begin
            chk(ext_sel == c, "R9 select first cycle", 32'(ext_sel), 32'(c));
            ext_in = ~ev;
            @(negedge clk);
            req = 1'b0;
            chk(ext_sel == c, "R9 select second cycle", 32'(ext_sel), 32'(c));
            chk(done == 1'b0, "R11 no early done", 32'(done), 32'd0);
            ext_in = ev;
            @(negedge clk);
            chk(done == 1'b1, "R11 external latency", 32'(done), 32'd1);
            chk(ext_sel == 4'd0, "R9 select cleared", 32'(ext_sel), 32'd0);
        end else begin
            chk(ext_sel == 4'd0, "R9 select idle in flag mode", 32'(ext_sel), 32'd0);
            @(negedge clk);
            req = 1'b0;
            chk(done == 1'b1, "R11 flag latency", 32'(done), 32'd1);
        end
        @(negedge clk);
        chk(done == 1'b0, "R11 single pulse", 32'(done), 32'd0);
        ext_in = 1'b0;
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R11 unexpected result", 32'(next_pc), 32'd0);
            end else begin
                logic [16:0] e;
                string       t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(taken == e[16], {t, " taken"}, 32'(taken), 32'(e[16]));
                chk(next_pc == e[15:0], {t, " next_pc"}, 32'(next_pc), 32'(e[15:0]));
            end
        end
    end

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(ready == 1'b1, "R1 ready", 32'(ready), 32'd1);
        chk(done == 1'b0, "R1 done", 32'(done), 32'd0);
        chk(taken == 1'b0, "R1 taken", 32'(taken), 32'd0);
        chk(next_pc == 16'd0, "R1 next_pc", 32'(next_pc), 32'd0);
        chk(ext_sel == 4'd0, "R1 ext_sel", 32'(ext_sel), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        issue(4'b0000, 4'b0000, 16'h0010, 1'b0, 16'h1000, 1'b0, 1'b0, 1'b0, "R2");
        issue(4'b0000, 4'b1111, 16'h0010, 1'b1, 16'h1000, 1'b0, 1'b0, 1'b0, "R3");
        issue(4'b1000, 4'b1111, 16'h0040, 1'b0, 16'h2222, 1'b0, 1'b0, 1'b0, "R4");
        issue(4'b0000, 4'b0000, 16'h0003, 1'b0, 16'hFFFF, 1'b0, 1'b0, 1'b0, "R10");
        issue(4'b0000, 4'b0000, 16'h0010, 1'b1, 16'h0001, 1'b0, 1'b0, 1'b0, "R10");
        issue(4'b1000, 4'b0000, 16'h0000, 1'b0, 16'hFFFE, 1'b0, 1'b0, 1'b0, "R10");
        // R11: request held high while busy must be ignored
        issue(4'b0100, 4'b0100, 16'h0008, 1'b0, 16'h0300, 1'b0, 1'b0, 1'b1, "R11");

        for (int c = 0; c < 16; c++) begin
            for (int f = 0; f < 16; f++) begin
                issue(4'(c), 4'(f), 16'(f * 37 + c), 1'(f & 1), 16'(c * 4096 + f * 3),
                      1'b0, 1'b0, 1'b0, code_tag(4'(c)));
            end
        end

        issue(4'b1011, 4'b0000, 16'h0020, 1'b0, 16'h0400, 1'b1, 1'b1, 1'b0, "R9");
        issue(4'b0110, 4'b1111, 16'h0020, 1'b1, 16'h0400, 1'b1, 1'b0, 1'b0, "R9");
        issue(4'b0000, 4'b0000, 16'h0005, 1'b1, 16'h0002, 1'b1, 1'b1, 1'b0, "R9");
        issue(4'b1000, 4'b1010, 16'h0100, 1'b0, 16'hFFF0, 1'b1, 1'b1, 1'b0, "R9");

        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, "R11 all results delivered", 32'(exp_q.size()), 32'd0);
        finish_run();
    end

endmodule